// File: doc/BRIEF.md
# Sector Transfer Termination Controller

This block follows a single- or multi-sector data transfer byte by byte and decides when and how it ends. A command start loads the direction, the first sector number, the last sector number and a size code. The sector length is 128 << code bytes. From then on the block counts bytes against the current sector. When a sector's final byte is counted, the block either moves on to the next sector or closes the transfer.

A transfer ends in one of three ways. The first is explicitly, on the terminal-count input. The second is implicitly, when the last sector of the transfer completes. The third is implicitly, on an underrun/overrun indication. When a transfer is stopped part-way through a sector, the block first fills the rest of that sector with pad bytes, one per cycle, and only then ends the transfer. At the end it emits a one-cycle done pulse together with a status that gives the cause of the ending. The status marks an ending as abnormal unless terminal count caused it. The status stays valid until the next command starts.

Host bytes arrive on a valid/ready interface. `host_ready` is high only while the transfer is in progress and not padding. A byte counts as transferred only in a cycle where both `host_valid` and `host_ready` are high. A host that holds `host_valid` while `host_ready` is low loses nothing, because no byte is taken in that cycle. When the host sends data toward the drive, the sector count advances only on media-side FIFO reads, one byte per `media_rd` cycle. In that direction host handshakes are accepted but do not move the count. Size codes above `MAX_CODE` are treated as `MAX_CODE`.

Top module: `sector_term_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `pad_req`, `host_ready` and `st_valid` are all 0, and `st_cause` is 0.
- R2: A `start` pulse while not busy loads `dir_wr`, `size_code`, `first_sec` and `eot_sec`, and clears `st_valid`. From the next cycle `busy` is 1 and `host_ready` is 1 until padding or the end.
- R3: With `dir_wr`=0 a byte is counted on each `host_valid`&`host_ready` cycle. With `dir_wr`=1 a byte is counted on each `media_rd` cycle only, and host handshakes leave the count unchanged, so they can never end the transfer.
- R4: A sector holds 128 << `size_code` bytes. After a sector's final byte, when no ending applies, counting continues with the next sector number.
- R5: When the final byte of sector number `eot_sec` is counted and neither `tc` nor `xrun` is high, the transfer ends with `st_cause`=2 (end of track) and `st_abn`=1.
- R6: `tc` at a sector boundary, meaning no byte of the current sector counted yet, ends the transfer with no padding: `done` is high in the next cycle, `st_cause`=1 and `st_abn`=0.
- R7: `tc` in mid-sector starts padding. `pad_req` is 1 and `host_ready` is 0 for exactly the number of bytes still missing from the sector. The transfer then ends with `st_cause`=1 and `st_abn`=0.
- R8: `xrun` acts like `tc`, including padding, but ends with `st_cause`=3 and `st_abn`=1.
- R9: If `tc`, `xrun` or both fall in the cycle of a sector's final byte, no padding takes place. `tc` wins over `xrun`, and both win over end of track.
- R10: `done` is high for exactly one cycle per transfer and `st_valid` rises with it. `st_valid`, `st_cause` and `st_abn` then hold until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command start pulse |
| dir_wr | input | 1 | 1: host to drive, 0: drive to host |
| size_code | input | CODE_W | Sector size code, length 128 << code |
| first_sec | input | SEC_W | First sector number |
| eot_sec | input | SEC_W | Last sector number of the transfer |
| host_valid | input | 1 | Host byte offered |
| host_ready | output | 1 | Host byte accepted in this cycle if valid |
| media_rd | input | 1 | Media side read one byte from the FIFO |
| tc | input | 1 | Terminal count |
| xrun | input | 1 | Underrun/overrun indication |
| busy | output | 1 | Transfer in progress |
| pad_req | output | 1 | Pad byte generated in this cycle |
| done | output | 1 | One-cycle end-of-transfer pulse |
| st_valid | output | 1 | Status valid |
| st_abn | output | 1 | Abnormal termination |
| st_cause | output | 2 | 0 none, 1 terminal count, 2 end of track, 3 underrun/overrun |

## Verification
The critical overlap is a terminal count or an underrun/overrun arriving in the same cycle as the final byte of the last sector. In that cycle three endings compete, and padding must not start. The bench provokes this by raising `tc` and `xrun` together with the last host handshake of the end-of-track sector, and again with `xrun` alone. It judges the result from the cause code, the abnormal flag, and a pad count of zero before `done`. A second overlap, `tc` exactly at a sector boundary, must give `done` in the very next cycle.

// File: rtl/stc_pkg.sv
package stc_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_TC   = 2'd1,
    CAUSE_EOT  = 2'd2,
    CAUSE_XRUN = 2'd3
  } cause_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_PAD  = 2'd2
  } state_e;
endpackage

// File: rtl/stc_byte_ctr.sv
module stc_byte_ctr #(
  parameter int MAX_CODE = 3,
  parameter int CODE_W   = 3,
  localparam int CNT_W   = 7 + MAX_CODE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  cnt,
  output logic              last,
  output logic              zero
);
  logic [CODE_W-1:0] code_c;
  logic [CNT_W-1:0]  size_m1;

  always_comb begin
    code_c  = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
    size_m1 = {CNT_W{1'b1}} >> (CODE_W'(MAX_CODE) - code_c);
    last    = (cnt == size_m1);
    zero    = (cnt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (clr)       cnt <= '0;
    else if (inc)       cnt <= last ? '0 : cnt + 1'b1;
  end

  // R4
  cnt_in_sector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= size_m1);
endmodule

// File: rtl/stc_sector_ctr.sv
module stc_sector_ctr #(
  parameter int SEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEC_W-1:0] first,
  input  logic [SEC_W-1:0] eot,
  input  logic             adv,
  output logic [SEC_W-1:0] cur,
  output logic             at_eot
);
  logic [SEC_W-1:0] eot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur   <= '0;
      eot_q <= '0;
    end else if (load) begin
      cur   <= first;
      eot_q <= eot;
    end else if (adv) begin
      cur   <= cur + 1'b1;
    end
  end

  assign at_eot = (cur == eot_q);

  // R5
  no_adv_past_eot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> !at_eot);
endmodule

// File: rtl/stc_end_fsm.sv
module stc_end_fsm
  import stc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   dir_q,
  input  logic   host_valid,
  input  logic   media_rd,
  input  logic   tc,
  input  logic   xrun,
  input  logic   last,
  input  logic   zero,
  input  logic   at_eot,
  output logic   load,
  output logic   inc,
  output logic   adv,
  output logic   host_ready,
  output logic   busy,
  output logic   pad_req,
  output logic   done,
  output logic   st_valid,
  output cause_e st_cause
);
  state_e state, state_n;
  cause_e pend, pend_n, end_cause;
  logic   beat, fin, finish;

  always_comb begin
    host_ready = (state == ST_XFER);
    pad_req    = (state == ST_PAD);
    busy       = (state != ST_IDLE);
    load       = (state == ST_IDLE) && start;
    beat       = (state == ST_XFER) && (dir_q ? media_rd : host_valid);
    fin        = beat && last;
    inc        = beat || pad_req;
    state_n    = state;
    pend_n     = pend;
    finish     = 1'b0;
    end_cause  = CAUSE_NONE;
    adv        = 1'b0;
    unique case (state)
      ST_IDLE: if (start) state_n = ST_XFER;
      ST_XFER: begin
        if (tc || xrun) begin
          end_cause = tc ? CAUSE_TC : CAUSE_XRUN;
          if (fin || (zero && !beat)) begin
            finish  = 1'b1;
            state_n = ST_IDLE;
          end else begin
            pend_n  = end_cause;
            state_n = ST_PAD;
          end
        end else if (fin) begin
          if (at_eot) begin
            finish    = 1'b1;
            end_cause = CAUSE_EOT;
            state_n   = ST_IDLE;
          end else begin
            adv = 1'b1;
          end
        end
      end
      ST_PAD: if (last) begin
        finish    = 1'b1;
        end_cause = pend;
        state_n   = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pend     <= CAUSE_NONE;
      done     <= 1'b0;
      st_valid <= 1'b0;
      st_cause <= CAUSE_NONE;
    end else begin
      state <= state_n;
      pend  <= pend_n;
      done  <= finish;
      if (load) begin
        st_valid <= 1'b0;
        st_cause <= CAUSE_NONE;
      end else if (finish) begin
        st_valid <= 1'b1;
        st_cause <= end_cause;
      end
    end
  end

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  done_has_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> st_valid && (st_cause != CAUSE_NONE));
  // R10
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !start) |=> $stable(st_cause) && st_valid);
  // R7
  pad_blocks_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_req |-> !host_ready && busy);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy && !st_valid);
endmodule

// File: rtl/sector_term_ctrl.sv
module sector_term_ctrl
  import stc_pkg::*;
#(
  parameter int SEC_W    = 8,
  parameter int MAX_CODE = 3,
  parameter int CODE_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_wr,
  input  logic [CODE_W-1:0] size_code,
  input  logic [SEC_W-1:0]  first_sec,
  input  logic [SEC_W-1:0]  eot_sec,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              media_rd,
  input  logic              tc,
  input  logic              xrun,
  output logic              busy,
  output logic              pad_req,
  output logic              done,
  output logic              st_valid,
  output logic              st_abn,
  output logic [1:0]        st_cause
);
  localparam int CNT_W = 7 + MAX_CODE;

  logic              load, inc, adv, last, zero, at_eot;
  logic              dir_q;
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  bcnt;
  logic [SEC_W-1:0]  cur_sec;
  cause_e            cause;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      code_q <= '0;
    end else if (load) begin
      dir_q  <= dir_wr;
      code_q <= size_code;
    end
  end

  stc_byte_ctr #(.MAX_CODE(MAX_CODE), .CODE_W(CODE_W)) u_bytes (
    .clk(clk), .rst_n(rst_n), .clr(load), .inc(inc), .code(code_q),
    .cnt(bcnt), .last(last), .zero(zero));

  stc_sector_ctr #(.SEC_W(SEC_W)) u_sect (
    .clk(clk), .rst_n(rst_n), .load(load), .first(first_sec), .eot(eot_sec),
    .adv(adv), .cur(cur_sec), .at_eot(at_eot));

  stc_end_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_q(dir_q),
    .host_valid(host_valid), .media_rd(media_rd), .tc(tc), .xrun(xrun),
    .last(last), .zero(zero), .at_eot(at_eot), .load(load), .inc(inc),
    .adv(adv), .host_ready(host_ready), .busy(busy), .pad_req(pad_req),
    .done(done), .st_valid(st_valid), .st_cause(cause));

  assign st_cause = cause;
  assign st_abn   = st_valid && (cause != CAUSE_TC);

  // R6
  tc_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pad_req && tc && zero && !(host_valid && !dir_q) && !(media_rd && dir_q))
      |=> done && !busy);
  // R3
  write_dir_host_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pad_req && dir_q && !media_rd && !tc && !xrun) |=> $stable(bcnt));
endmodule

// File: tb/sector_term_ctrl_test.sv
module sector_term_ctrl_test;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       start = 0, dir_wr = 0, host_valid = 0, media_rd = 0, tc = 0, xrun = 0;
  logic [2:0] size_code = 0;
  logic [7:0] first_sec = 0, eot_sec = 0;
  logic       host_ready, busy, pad_req, done, st_valid, st_abn;
  logic [1:0] st_cause;
  int total = 0, bad = 0, cycles = 0;

  always #2.5 clk = ~clk;

  sector_term_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_wr(dir_wr), .size_code(size_code),
    .first_sec(first_sec), .eot_sec(eot_sec), .host_valid(host_valid),
    .host_ready(host_ready), .media_rd(media_rd), .tc(tc), .xrun(xrun),
    .busy(busy), .pad_req(pad_req), .done(done), .st_valid(st_valid),
    .st_abn(st_abn), .st_cause(st_cause));

  typedef struct packed {
    logic        dir;
    logic [2:0]  code;
    logic [7:0]  first;
    logic [7:0]  eot;
    logic [15:0] nbytes;
    logic [1:0]  stop;   // 0 none, 1 tc, 2 xrun
    logic [1:0]  cause;
    logic [15:0] pad;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{dir:1'b0, code:3'd0, first:8'd1, eot:8'd2, nbytes:16'd256, stop:2'd0, cause:2'd2, pad:16'd0},
    '{dir:1'b1, code:3'd0, first:8'd5, eot:8'd5, nbytes:16'd128, stop:2'd0, cause:2'd2, pad:16'd0},
    '{dir:1'b0, code:3'd0, first:8'd1, eot:8'd4, nbytes:16'd138, stop:2'd1, cause:2'd1, pad:16'd118},
    '{dir:1'b1, code:3'd1, first:8'd0, eot:8'd3, nbytes:16'd300, stop:2'd2, cause:2'd3, pad:16'd212},
    '{dir:1'b0, code:3'd0, first:8'd1, eot:8'd4, nbytes:16'd128, stop:2'd1, cause:2'd1, pad:16'd0},
    '{dir:1'b0, code:3'd0, first:8'd1, eot:8'd9, nbytes:16'd1,   stop:2'd2, cause:2'd3, pad:16'd127}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start(input logic d, input logic [2:0] c, input logic [7:0] f, input logic [7:0] e);
    @(negedge clk);
    start = 1; dir_wr = d; size_code = c; first_sec = f; eot_sec = e;
    @(posedge clk); @(negedge clk);
    start = 0;
  endtask

  task automatic beats(input logic d, input int n);
    for (int i = 0; i < n; i++) begin
      if (d) media_rd = 1; else host_valid = 1;
      @(posedge clk); @(negedge clk);
    end
    media_rd = 0; host_valid = 0;
  endtask

  task automatic pulse(input logic [1:0] k);
    if (k == 2'd0) return;
    if (k == 2'd1) tc = 1; else xrun = 1;
    @(posedge clk); @(negedge clk);
    tc = 0; xrun = 0;
  endtask

  // called at a negedge; returns pad cycles seen before done, -1 on timeout
  task automatic wait_done(output int padc, output int hr_bad);
    padc = 0; hr_bad = 0;
    for (int i = 0; i < 3000; i++) begin
      if (done) return;
      if (pad_req) begin padc++; if (host_ready) hr_bad++; end
      @(posedge clk); @(negedge clk);
    end
    padc = -1;
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int padc, hrb;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !pad_req && !host_ready, "R1 idle outputs", {busy, done, pad_req, host_ready}, 0);
    check(!st_valid && st_cause == 0, "R1 status", {st_valid, st_cause}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !done, "R1 after release", {busy, done}, 0);

    // table walk: R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      do_start(VEC[v].dir, VEC[v].code, VEC[v].first, VEC[v].eot);
      check(busy && host_ready && !st_valid, "R2 start", {busy, host_ready, st_valid}, 6);
      beats(VEC[v].dir, int'(VEC[v].nbytes));
      pulse(VEC[v].stop);
      wait_done(padc, hrb);
      check(padc == int'(VEC[v].pad), "R7/R8 pad count", padc, int'(VEC[v].pad));
      check(hrb == 0, "R7 host_ready low while padding", hrb, 0);
      check(st_valid && st_cause == VEC[v].cause, "R5/R6/R8 cause", st_cause, int'(VEC[v].cause));
      check(st_abn == (VEC[v].cause != 2'd1), "R5/R8 abnormal flag", st_abn, int'(VEC[v].cause != 2'd1));
      @(negedge clk);
      check(!done && !busy, "R10 done single cycle", {done, busy}, 0);
    end

    // R10 status held, cleared by start
    repeat (5) @(negedge clk);
    check(st_valid && st_cause == 2'd3, "R10 status hold", st_cause, 3);
    do_start(1'b0, 3'd0, 8'd0, 8'd7);
    check(!st_valid && st_cause == 0, "R10 status cleared by start", {st_valid, st_cause}, 0);
    // R6 tc at boundary gives done next cycle
    pulse(2'd1);
    check(done && st_cause == 2'd1 && !st_abn, "R6 immediate end", {done, st_cause}, 5);

    // R9 tc and xrun with last byte of eot sector
    do_start(1'b0, 3'd0, 8'd3, 8'd3);
    beats(1'b0, 127);
    host_valid = 1; tc = 1; xrun = 1;
    @(posedge clk); @(negedge clk);
    host_valid = 0; tc = 0; xrun = 0;
    check(done && !pad_req, "R9 no pad on final byte", {done, pad_req}, 2);
    check(st_cause == 2'd1 && !st_abn, "R9 tc wins", st_cause, 1);

    // R9 xrun with last byte beats eot
    do_start(1'b0, 3'd0, 8'd3, 8'd3);
    beats(1'b0, 127);
    host_valid = 1; xrun = 1;
    @(posedge clk); @(negedge clk);
    host_valid = 0; xrun = 0;
    check(done && st_cause == 2'd3 && st_abn, "R9 xrun over eot", st_cause, 3);

    // R3 host beats ignored in write direction
    do_start(1'b1, 3'd0, 8'd0, 8'd0);
    beats(1'b0, 140);
    check(busy && !done && !st_valid, "R3 host beats ignored", {busy, done, st_valid}, 4);
    beats(1'b1, 127);
    check(busy && !done, "R3 one byte short", {busy, done}, 2);
    beats(1'b1, 1);
    check(done && st_cause == 2'd2, "R3 media reads end sector", st_cause, 2);

    // R4 size code 2 gives 512 bytes, sector advance
    do_start(1'b0, 3'd2, 8'd0, 8'd1);
    beats(1'b0, 511);
    check(busy && !done, "R4 512-byte sector not yet done", {busy, done}, 2);
    beats(1'b0, 513);
    check(done && st_cause == 2'd2, "R4 two sectors then eot", st_cause, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule